// File: doc/BRIEF.md
# Single-Channel DMA Engine with Block and Cycle-Steal Transfer

This block moves a programmed number of words between one peripheral and system memory without the processor copying them. Software writes a device address, a memory start address and a word count, then writes the control register with a direction bit, a mode bit and a start bit. When the peripheral raises its request line, the engine asks the system bus arbiter for ownership and waits for the grant. Each word is then moved in two bus phases: a read from the source, held in an internal data register, and a write to the destination. After each word the memory address goes up by one and the count goes down by one.

Two ownership policies exist. In block mode the engine keeps the bus from the first word to the last. In cycle-steal mode it gives the bus back after every word and waits for the next device request and the next grant before it moves another. When the count reaches zero the engine sets a done flag that drives the interrupt line. Reading the status register clears it. A start with a count of zero completes at once and performs no bus cycle.

Top module: `dma_engine`

## Requirements
- R1: Register select 1, 2 and 3 hold the device address, memory address and word count. They are written when `regWr` is high and the engine is idle, and they read back on `regRdata` the same cycle `regSel` selects them.
- R2: `busReq` rises only after `dreq` is seen high while the channel is armed. `busRd` and `busWr` are only active while `busReq` and `busGrant` are both high.
- R3: Each word uses one `busRd` cycle, followed in the next cycle by one `busWr` cycle that carries the data read. With control bit 1 = 1 the read targets the device (`busIoSel`=1, `busAddr`=device address) and the write targets memory. With control bit 1 = 0 the direction is reversed.
- R4: After each word the memory address register increments by one and the count decrements by one. At completion they read back as start+N and 0.
- R5: With control bit 2 = 0 (block mode), `busReq` stays high from the first word to the last, which gives one ownership period per transfer.
- R6: With control bit 2 = 1 (cycle-steal mode), `busReq` is low in the cycle after every word's write cycle, which gives exactly N ownership periods for N words.
- R7: When the last word is written, the done flag (status bit 1) and `irq` go high and busy (status bit 0) goes low in the next cycle. `irq` is never high while `busReq` is high.
- R8: A read of register select 0 returns status: bit 0 busy, bit 1 done, bit 2 direction, bit 3 mode. That read clears done and `irq` from the following cycle.
- R9: A start (control bit 0 = 1) with the count at zero sets done and `irq` in the next cycle without any `busReq`, `busRd` or `busWr`.
- R10: `dack` is high exactly in each word's write cycle, once per word.
- R11: After reset `busReq`, `busRd`, `busWr`, `dack` and `irq` are low and the status reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register select: 0 control/status, 1 device address, 2 memory address, 3 count |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (clears done when select is 0) |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data |
| dreq | input | 1 | Device transfer request |
| dack | output | 1 | Device acknowledge, one pulse per word |
| busReq | output | 1 | Bus ownership request |
| busGrant | input | 1 | Bus ownership grant |
| busAddr | output | ADDR_W | Bus address |
| busIoSel | output | 1 | 1 = device space, 0 = memory space |
| busRd | output | 1 | Bus read strobe |
| busWr | output | 1 | Bus write strobe |
| busWdata | output | DATA_W | Bus write data |
| busRdata | input | DATA_W | Bus read data, valid in the read cycle |
| irq | output | 1 | Completion interrupt |

## Verification
The checker watches, on every cycle, the protocol rules that hold regardless of the data. Bus strobes appear only under a held grant, every write follows a read, device acknowledges coincide with writes, the request drops after each stolen word, and the interrupt never overlaps bus ownership. The bench scenarios cover what needs a whole transfer to show. These are the data landing at the right addresses in both directions, the final address and count readback, the number of ownership periods per mode, the zero-count shortcut and the status read that clears the interrupt.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_DEV,
    ST_ASK_BUS,
    ST_READ,
    ST_WRITE
  } dmaState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic rdPhase;   // source read cycle, captures busRdata
    logic wrPhase;   // destination write cycle
    logic advance;   // step address and count
  } dpStrobe_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DEV  = 2'd1;
  localparam logic [1:0] SEL_MEM  = 2'd2;
  localparam logic [1:0] SEL_CNT  = 2'd3;

endpackage

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      statusRd,
  input  logic      cntZero,
  input  logic      lastWord,
  input  logic      steal,
  input  logic      dreq,
  input  logic      busGrant,
  output dpStrobe_t strobe,
  output logic      busReq,
  output logic      busRd,
  output logic      busWr,
  output logic      dack,
  output logic      busy,
  output logic      done
);

  dmaState_t state, stateNxt;
  logic      doneNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:     if (startReq && !cntZero) stateNxt = ST_WAIT_DEV;
      ST_WAIT_DEV: if (dreq) stateNxt = ST_ASK_BUS;
      ST_ASK_BUS:  if (busGrant) stateNxt = ST_READ;
      ST_READ:     stateNxt = ST_WRITE;
      ST_WRITE: begin
        if (lastWord)   stateNxt = ST_IDLE;
        else if (steal) stateNxt = ST_WAIT_DEV;
        else            stateNxt = ST_READ;
      end
      default:     stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    doneNxt = done;
    if (statusRd) doneNxt = 1'b0;
    if (state == ST_IDLE && startReq) doneNxt = cntZero;
    if (state == ST_WRITE && lastWord) doneNxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= doneNxt;
    end
  end

  assign busy           = (state != ST_IDLE);
  assign busReq         = (state == ST_ASK_BUS) || (state == ST_READ) || (state == ST_WRITE);
  assign busRd          = (state == ST_READ);
  assign busWr          = (state == ST_WRITE);
  assign dack           = (state == ST_WRITE);
  assign strobe.rdPhase = (state == ST_READ);
  assign strobe.wrPhase = (state == ST_WRITE);
  assign strobe.advance = (state == ST_WRITE);

endmodule

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              busy,
  input  logic              done,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busIoSel,
  output logic [DATA_W-1:0] busWdata,
  output logic              cfgSteal,
  output logic              cntZero,
  output logic              lastWord
);

  localparam int STAT_W = 4;

  logic [ADDR_W-1:0] devAddr;
  logic [ADDR_W-1:0] memAddr;
  logic [CNT_W-1:0]  wordCnt;
  logic              cfgToMem;
  logic [DATA_W-1:0] dataHold;
  logic              progOk;

  assign progOk = regWr && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devAddr  <= '0;
      memAddr  <= '0;
      wordCnt  <= '0;
      cfgToMem <= 1'b0;
      cfgSteal <= 1'b0;
      dataHold <= '0;
    end else begin
      if (progOk) begin
        unique case (regSel)
          SEL_CTRL: begin
            cfgToMem <= regWdata[1];
            cfgSteal <= regWdata[2];
          end
          SEL_DEV: devAddr <= regWdata[ADDR_W-1:0];
          SEL_MEM: memAddr <= regWdata[ADDR_W-1:0];
          default: wordCnt <= regWdata[CNT_W-1:0];
        endcase
      end
      if (strobe.rdPhase) dataHold <= busRdata;
      if (strobe.advance) begin
        memAddr <= memAddr + ADDR_W'(1);
        wordCnt <= wordCnt - CNT_W'(1);
      end
    end
  end

  assign cntZero  = (wordCnt == '0);
  assign lastWord = (wordCnt == CNT_W'(1));
  assign busWdata = dataHold;

  // read phase hits the source, write phase the destination
  always_comb begin
    busIoSel = 1'b0;
    busAddr  = '0;
    if (strobe.rdPhase) begin
      busIoSel = cfgToMem;
      busAddr  = cfgToMem ? devAddr : memAddr;
    end else if (strobe.wrPhase) begin
      busIoSel = !cfgToMem;
      busAddr  = cfgToMem ? memAddr : devAddr;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regSel)
      SEL_CTRL: regRdata[STAT_W-1:0] = {cfgSteal, cfgToMem, done, busy};
      SEL_DEV:  regRdata[ADDR_W-1:0] = devAddr;
      SEL_MEM:  regRdata[ADDR_W-1:0] = memAddr;
      default:  regRdata[CNT_W-1:0]  = wordCnt;
    endcase
  end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              dreq,
  output logic              dack,
  output logic              busReq,
  input  logic              busGrant,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busIoSel,
  output logic              busRd,
  output logic              busWr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              irq
);

  dpStrobe_t strobe;
  logic      busy, done, cntZero, lastWord, cfgSteal;
  logic      startReq, statusRd;

  assign startReq = regWr && (regSel == SEL_CTRL) && regWdata[0] && !busy;
  assign statusRd = regRd && (regSel == SEL_CTRL);
  assign irq      = done;

  dma_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .statusRd (statusRd),
    .cntZero  (cntZero),
    .lastWord (lastWord),
    .steal    (cfgSteal),
    .dreq     (dreq),
    .busGrant (busGrant),
    .strobe   (strobe),
    .busReq   (busReq),
    .busRd    (busRd),
    .busWr    (busWr),
    .dack     (dack),
    .busy     (busy),
    .done     (done)
  );

  dma_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .regSel   (regSel),
    .regWr    (regWr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .busIoSel (busIoSel),
    .busWdata (busWdata),
    .cfgSteal (cfgSteal),
    .cntZero  (cntZero),
    .lastWord (lastWord)
  );

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk (
  input logic clk,
  input logic rstN,
  input logic busReq,
  input logic busGrant,
  input logic busRd,
  input logic busWr,
  input logic dack,
  input logic irq,
  input logic cfgSteal
);

  AST_ACCESS_UNDER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |-> (busReq && busGrant)); // R2

  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> busWr); // R3

  AST_WRITE_HAS_READ: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> $past(busRd)); // R3

  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && cfgSteal) |=> !busReq); // R6

  AST_IRQ_OFF_BUS: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !irq); // R7

  AST_DACK_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    dack |-> busWr); // R10

endmodule

bind dma_engine dma_engine_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busReq   (busReq),
  .busGrant (busGrant),
  .busRd    (busRd),
  .busWr    (busWr),
  .dack     (dack),
  .irq      (irq),
  .cfgSteal (cfgSteal)
);

// File: tb/test_dma_engine.sv
`timescale 1ns/1ps
module test_dma_engine;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        regSel = '0;
  logic              regWr = 1'b0;
  logic              regRd = 1'b0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic              dreq = 1'b0;
  logic              dack;
  logic              busReq;
  logic              busGrant;
  logic [ADDR_W-1:0] busAddr;
  logic              busIoSel;
  logic              busRd;
  logic              busWr;
  logic [DATA_W-1:0] busWdata;
  logic [DATA_W-1:0] busRdata;
  logic              irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_dma_engine (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .dreq(dreq), .dack(dack),
    .busReq(busReq), .busGrant(busGrant), .busAddr(busAddr), .busIoSel(busIoSel),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata),
    .irq(irq)
  );

  // ---------------- bus, memory and device models ----------------
  logic [DATA_W-1:0] mem [0:255];
  logic [DATA_W-1:0] devLog [0:255];
  int devRdIdx = 0, devWrIdx = 0;
  int ownCnt = 0, dackCnt = 0, accCnt = 0;
  logic prevReq = 1'b0;

  function automatic logic [DATA_W-1:0] devWord(int k);
    return 32'h9E37_79B1 * (k + 1) ^ 32'h0BAD_F00D;
  endfunction

  function automatic logic [DATA_W-1:0] memInit(int a);
    return {8'hA5, 8'(a), 8'h3C, 8'(a * 7)};
  endfunction

  assign busRdata = busIoSel ? devWord(devRdIdx) : mem[busAddr[7:0]];

  always @(posedge clk) begin
    if (!rstN) begin
      busGrant <= 1'b0;
      prevReq  <= 1'b0;
      for (int i = 0; i < 256; i++) mem[i] <= memInit(i);
    end else begin
      busGrant <= busReq && (busGrant || ($urandom % 3 == 0));
      prevReq  <= busReq;
      if (busReq && !prevReq) ownCnt <= ownCnt + 1;
      if (dack) dackCnt <= dackCnt + 1;
      if (busRd || busWr) accCnt <= accCnt + 1;
      if (busRd && busIoSel) devRdIdx <= devRdIdx + 1;
      if (busWr && busIoSel) begin
        devLog[devWrIdx[7:0]] <= busWdata;
        devWrIdx <= devWrIdx + 1;
      end
      if (busWr && !busIoSel) mem[busAddr[7:0]] <= busWdata;
    end
  end

  always @(negedge clk) dreq <= ($urandom % 4) != 0;

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [DATA_W-1:0] val);
    @(negedge clk);
    regSel = sel; regWdata = val; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [DATA_W-1:0] val);
    @(negedge clk);
    regSel = sel; regRd = 1'b1;
    #3 val = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [DATA_W-1:0] val);
    @(negedge clk);
    regSel = sel;
    #3 val = regRdata;
  endtask

  task automatic runXfer(input bit toMem, input bit steal, input int memBase,
                         input int devBase, input int n);
    logic [DATA_W-1:0] snap [0:63];
    logic [DATA_W-1:0] v;
    int own0, dack0, rd0, wr0, errs, wait0;
    for (int k = 0; k < n; k++) snap[k] = mem[memBase + k];
    own0 = ownCnt; dack0 = dackCnt; rd0 = devRdIdx; wr0 = devWrIdx;
    regWrite(2'd1, DATA_W'(devBase));
    regWrite(2'd2, DATA_W'(memBase));
    regWrite(2'd3, DATA_W'(n));
    peek(2'd1, v); chk(v == DATA_W'(devBase), "R1 device address readback", v, devBase);
    peek(2'd3, v); chk(v == DATA_W'(n), "R1 count readback", v, n);
    regWrite(2'd0, {29'd0, steal, toMem, 1'b1});
    wait0 = 0;
    while (!irq && wait0 < 5000) begin @(negedge clk); wait0++; end
    chk(irq, "R7 irq after transfer", irq, 1);
    errs = 0;
    for (int k = 0; k < n; k++) begin
      if (toMem) begin
        if (mem[memBase + k] !== devWord(rd0 + k)) errs++;
      end else begin
        if (devLog[(wr0 + k) % 256] !== snap[k]) errs++;
      end
    end
    chk(errs == 0, toMem ? "R3 device-to-memory data" : "R3 memory-to-device data", errs, 0);
    chk(ownCnt - own0 == (steal ? n : 1),
        steal ? "R6 one ownership per word" : "R5 one ownership per block",
        ownCnt - own0, steal ? n : 1);
    chk(dackCnt - dack0 == n, "R10 dack pulses", dackCnt - dack0, n);
    peek(2'd2, v); chk(v == DATA_W'(memBase + n), "R4 final memory address", v, memBase + n);
    peek(2'd3, v); chk(v == '0, "R4 final count", v, 0);
    regRead(2'd0, v);
    chk(v[3:0] == {steal, toMem, 2'b10}, "R8 status busy0 done1", v[3:0], {steal, toMem, 2'b10});
    #1 chk(!irq, "R8 status read clears irq", irq, 0);
  endtask

  // ---------------- scenario ----------------
  initial begin
    logic [DATA_W-1:0] v;
    int acc0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    chk(!busReq && !busRd && !busWr && !dack && !irq, "R11 outputs idle after reset",
        {busReq, busRd, busWr, dack, irq}, 0);
    peek(2'd0, v); chk(v == '0, "R11 status after reset", v, 0);

    // directed: single word in each mode and direction
    runXfer(1'b1, 1'b0, 8, 3, 1);
    runXfer(1'b0, 1'b1, 20, 9, 1);
    // directed: longer blocks
    runXfer(1'b1, 1'b0, 100, 16, 40);
    runXfer(1'b0, 1'b1, 150, 32, 40);

    // zero count completes immediately with no bus activity
    acc0 = accCnt;
    regWrite(2'd3, '0);
    regWrite(2'd0, 32'h1);
    #2 chk(irq && !busReq, "R9 zero count irq without bus request", {irq, busReq}, 2'b10);
    repeat (3) @(negedge clk);
    chk(accCnt == acc0, "R9 zero count no bus cycles", accCnt - acc0, 0);
    regRead(2'd0, v);
    chk(v[1:0] == 2'b10, "R9 zero count status done", v[1:0], 2'b10);

    // constrained random transfers
    for (int t = 0; t < 8; t++) begin
      int n = 1 + ($urandom % 24);
      int base = $urandom % (256 - n);
      runXfer(1'($urandom % 2), 1'($urandom % 2), base, $urandom % 4096, n);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule